// File: doc/BRIEF.md
# E1 Receive Alignment Pulse Generator

This block drives one alignment strobe for a 2.048 Mbit/s E1 receive stream. It runs on the recovered receive clock. An upstream framer marks the start of each frame and, when it has found them, the starts of the CRC multiframe and the signalling multiframe. The block keeps a bit position inside the 256-bit frame. It also keeps two separate 16-frame counters, one for CRC multiframing and one for signalling multiframing. A two-bit select picks which of these alignments the strobe marks.

The 16-frame counters keep running when their multiframing mode is switched off. The strobe then still marks every 16th frame, counted from the frame alignment. A single output pin can therefore serve as a frame, CRC-multiframe or signalling-multiframe marker.

Top module: `e1_rx_align_strobe`

## Requirements
- R1: After the first frame start, bit positions run 1 to 256 and wrap to 1. With select 00 the strobe is high in the cycle after each sampled frame start and in every 256th cycle after that.
- R2: The strobe is never high for two cycles in a row unless a new frame start was sampled. It is high only during bit 1.
- R3: Select 01 gives a strobe only during bit 1 of frame 1 of the CRC multiframe, once every 16 frames.
- R4: Select 10 gives a strobe only during bit 1 of frame 1 of the signalling multiframe, once every 16 frames.
- R5: A resync input sampled high together with a frame start, while its enable is high, puts its counter at frame 1. A resync input without a frame start has no effect.
- R6: While a multiframe enable is low, its resync input is ignored and its counter keeps stepping through 16 frames, so the strobe still marks every 16th frame.
- R7: The CRC and signalling counters are independent. A resync of one does not move the other.
- R8: Select 11 behaves as select 00.
- R9: A frame start at any bit position moves the bit position to 1. Both frame counters then advance by one frame, unless a resync applies.
- R10: Reset clears all counters. The strobe stays low until the first frame start, and that first frame start sets both frame counters to frame 1.
- R11: The select input is used only at a frame boundary. Changing it inside a frame produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | High for one cycle: bit 1 of a frame follows |
| crc_resync | input | 1 | With frame_start, the new frame is CRC frame 1 |
| sig_resync | input | 1 | With frame_start, the new frame is signalling frame 1 |
| crc_mf_en | input | 1 | CRC multiframing enabled; resync honoured |
| sig_mf_en | input | 1 | Signalling multiframing enabled; resync honoured |
| align_sel | input | 2 | 00/11 frame, 01 CRC multiframe, 10 signalling multiframe |
| align_strobe | output | 1 | One-cycle alignment strobe |

## Verification
The strobe is registered. It rises in the cycle that directly follows the clock edge at which a frame start is sampled. After that, it rises 256 cycles later on each free-running wrap. With a multiframe select, the strobe appears 16 × 256 cycles apart. The bench drives inputs on the falling edge and updates its reference model on the rising edge. It compares the strobe on the next falling edge, so each result is checked in exactly the cycle it is due. The windowed strobe counts in the directed checks are laid out so that due strobes fall at whole multiples of 256 cycles from a known strobe.

// File: rtl/e1ras_pkg.sv
package e1ras_pkg;
  typedef enum logic [1:0] {
    ALIGN_FRAME  = 2'b00,
    ALIGN_CRC    = 2'b01,
    ALIGN_SIG    = 2'b10,
    ALIGN_FRAME2 = 2'b11
  } align_sel_e;

  localparam int unsigned NUM_MF = 2;
  localparam int unsigned MF_CRC = 0;
  localparam int unsigned MF_SIG = 1;
endpackage

// File: rtl/e1ras_bit_ctr.sv
module e1ras_bit_ctr #(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  output logic boundary,
  output logic first_fs
);
  localparam int unsigned BIT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [BIT_W-1:0] LAST = BIT_W'(FRAME_BITS - 1);

  logic             locked_q;
  logic [BIT_W-1:0] bit_q;
  logic             wrap;

  assign wrap     = locked_q && (bit_q == LAST);
  assign boundary = frame_start || wrap;
  assign first_fs = frame_start && !locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      bit_q    <= '0;
    end else if (frame_start) begin
      locked_q <= 1'b1;
      bit_q    <= '0;
    end else if (locked_q) begin
      bit_q <= wrap ? '0 : bit_q + 1'b1;
    end
  end
endmodule

// File: rtl/e1ras_mf_ctr.sv
module e1ras_mf_ctr #(
  parameter int unsigned MF_FRAMES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic boundary,
  input  logic first_fs,
  input  logic frame_start,
  input  logic resync,
  input  logic enable,
  output logic at_first
);
  localparam int unsigned MF_W = (MF_FRAMES > 1) ? $clog2(MF_FRAMES) : 1;
  localparam logic [MF_W-1:0] LAST = MF_W'(MF_FRAMES - 1);

  logic [MF_W-1:0] cnt_q;
  logic [MF_W-1:0] cnt_nxt;
  logic            reload;

  assign reload = first_fs || (frame_start && resync && enable);

  always_comb begin
    cnt_nxt = cnt_q;
    if (boundary) begin
      if (reload)              cnt_nxt = '0;
      else if (cnt_q == LAST)  cnt_nxt = '0;
      else                     cnt_nxt = cnt_q + 1'b1;
    end
  end

  assign at_first = (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/e1ras_strobe_sel.sv
module e1ras_strobe_sel
  import e1ras_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       boundary,
  input  logic [1:0] sel,
  input  logic       crc_first,
  input  logic       sig_first,
  output logic       strobe_q
);
  align_sel_e mode;
  logic       hit;

  assign mode = align_sel_e'(sel);

  always_comb begin
    unique case (mode)
      ALIGN_CRC: hit = crc_first;
      ALIGN_SIG: hit = sig_first;
      default:   hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= boundary && hit;
  end
endmodule

// File: rtl/e1_rx_align_strobe.sv
module e1_rx_align_strobe
  import e1ras_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned MF_FRAMES  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic       crc_resync,
  input  logic       sig_resync,
  input  logic       crc_mf_en,
  input  logic       sig_mf_en,
  input  logic [1:0] align_sel,
  output logic       align_strobe
);
  logic              boundary;
  logic              first_fs;
  logic [NUM_MF-1:0] resync_v;
  logic [NUM_MF-1:0] enable_v;
  logic [NUM_MF-1:0] at_first_v;

  assign resync_v[MF_CRC] = crc_resync;
  assign resync_v[MF_SIG] = sig_resync;
  assign enable_v[MF_CRC] = crc_mf_en;
  assign enable_v[MF_SIG] = sig_mf_en;

  e1ras_bit_ctr #(.FRAME_BITS(FRAME_BITS)) u_bit (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .boundary    (boundary),
    .first_fs    (first_fs)
  );

  for (genvar g = 0; g < NUM_MF; g++) begin : g_mf
    e1ras_mf_ctr #(.MF_FRAMES(MF_FRAMES)) u_mf (
      .clk         (clk),
      .rst         (rst),
      .boundary    (boundary),
      .first_fs    (first_fs),
      .frame_start (frame_start),
      .resync      (resync_v[g]),
      .enable      (enable_v[g]),
      .at_first    (at_first_v[g])
    );
  end

  e1ras_strobe_sel u_sel (
    .clk       (clk),
    .rst       (rst),
    .boundary  (boundary),
    .sel       (align_sel),
    .crc_first (at_first_v[MF_CRC]),
    .sig_first (at_first_v[MF_SIG]),
    .strobe_q  (align_strobe)
  );
endmodule

// File: rtl/e1ras_chk.sv
module e1ras_chk #(
  parameter int unsigned FRAME_BITS = 256
) (
  input logic       clk,
  input logic       rst,
  input logic       frame_start,
  input logic [1:0] align_sel,
  input logic       align_strobe
);
  localparam int unsigned BIT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [BIT_W-1:0] LAST = BIT_W'(FRAME_BITS - 1);

  logic             seen_q;
  logic [BIT_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      pos_q  <= '0;
    end else if (frame_start) begin
      seen_q <= 1'b1;
      pos_q  <= '0;
    end else if (seen_q) begin
      pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end

  // R10: silent until a frame start has been seen
  p_quiet_before_lock_r10: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> !align_strobe);

  // R2: strobe appears only during bit 1
  p_only_bit1_r2: assert property (@(posedge clk) disable iff (rst)
    align_strobe |-> (pos_q == '0));

  // R2: one cycle wide unless a new frame start arrives
  p_single_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    (align_strobe && !frame_start) |=> !align_strobe);

  // R1, R8: frame mode marks each sampled frame start
  p_fs_marks_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_start && (align_sel[0] == align_sel[1])) |=> align_strobe);

  // R1: frame mode marks each free-running wrap
  p_wrap_marks_r1: assert property (@(posedge clk) disable iff (rst)
    (seen_q && pos_q == LAST && !frame_start && align_sel[0] == align_sel[1])
      |=> align_strobe);
endmodule

bind e1_rx_align_strobe e1ras_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .frame_start  (frame_start),
  .align_sel    (align_sel),
  .align_strobe (align_strobe)
);

// File: tb/e1_rx_align_strobe_bench.sv
`timescale 1ns/1ps
module e1_rx_align_strobe_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_start = 1'b0;
  logic       crc_resync = 1'b0;
  logic       sig_resync = 1'b0;
  logic       crc_mf_en = 1'b1;
  logic       sig_mf_en = 1'b1;
  logic [1:0] align_sel = 2'b00;
  logic       align_strobe;

  always #5 clk = ~clk;

  e1_rx_align_strobe u_e1_rx_align_strobe (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .crc_resync(crc_resync), .sig_resync(sig_resync),
    .crc_mf_en(crc_mf_en), .sig_mf_en(sig_mf_en),
    .align_sel(align_sel), .align_strobe(align_strobe)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    seen    = 0;
  bit    done    = 0;
  string phase   = "R10";

  // reference model
  bit m_locked = 0;
  int m_pos = 0, m_crc = 0, m_sig = 0;
  bit m_exp = 0;

  always @(posedge clk) begin
    bit b;
    if (rst) begin
      m_locked = 0; m_pos = 0; m_crc = 0; m_sig = 0; m_exp = 0;
    end else begin
      b = frame_start || (m_locked && m_pos == 255);
      if (frame_start && !m_locked) begin
        m_locked = 1; m_pos = 0; m_crc = 0; m_sig = 0;
      end else if (b) begin
        m_pos = 0;
        m_crc = (frame_start && crc_resync && crc_mf_en) ? 0 : (m_crc + 1) % 16;
        m_sig = (frame_start && sig_resync && sig_mf_en) ? 0 : (m_sig + 1) % 16;
      end else if (m_locked) begin
        m_pos = m_pos + 1;
      end
      case (align_sel)
        2'b01:   m_exp = b && (m_crc == 0);
        2'b10:   m_exp = b && (m_sig == 0);
        default: m_exp = b;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) check(align_strobe == m_exp, phase, align_strobe, m_exp);
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (align_strobe) seen++;
    end
  endtask

  task automatic pulse(input bit crs, input bit srs);
    @(negedge clk);
    frame_start = 1; crc_resync = crs; sig_resync = srs;
    @(negedge clk);
    frame_start = 0; crc_resync = 0; sig_resync = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #3_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(align_strobe == 0, "R10 reset", align_strobe, 0);
    rst = 0;
    seen = 0; tick(300);
    check(seen == 0, "R10 idle before frame start", seen, 0);

    phase = "R1";
    pulse(0, 0);
    check(align_strobe == 1, "R1 first strobe", align_strobe, 1);
    seen = 0; tick(1024);
    check(seen == 4, "R1 four frames", seen, 4);

    phase = "R9";
    tick(100); pulse(0, 0);
    seen = 0; tick(255);
    check(seen == 0, "R9 no strobe inside realigned frame", seen, 0);
    tick(1);
    check(seen == 1, "R9 strobe 256 after realign", seen, 1);

    phase = "R5";
    crc_resync = 1; tick(40); crc_resync = 0;
    align_sel = 2'b01; tick(60);
    pulse(1, 0);
    check(align_strobe == 1, "R5 resync gives frame 1", align_strobe, 1);
    phase = "R3";
    seen = 0; tick(8192);
    check(seen == 2, "R3 two CRC multiframes", seen, 2);

    phase = "R7";
    tick(700); pulse(0, 1);
    align_sel = 2'b10; tick(3);
    phase = "R4";
    seen = 0; tick(8189);
    check(seen == 2, "R4 two signalling multiframes", seen, 2);
    phase = "R7";
    align_sel = 2'b01; tick(4096);

    phase = "R6";
    crc_mf_en = 0; tick(333);
    pulse(1, 0);
    tick(9000);
    sig_mf_en = 0; align_sel = 2'b10; tick(77);
    pulse(0, 1); tick(9000);
    crc_mf_en = 1; sig_mf_en = 1;

    phase = "R8";
    align_sel = 2'b11; pulse(0, 0);
    seen = 0; tick(512);
    check(seen == 2, "R8 select 11 every frame", seen, 2);

    phase = "R11";
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); align_sel = 2'(k); #1;
      check(align_strobe == 0, "R11 mid-frame select change", align_strobe, 0);
    end
    align_sel = 2'b00; tick(600);

    phase = "R2";
    pulse(0, 0); pulse(0, 0); tick(300);

    rst = 1; tick(3);
    check(align_strobe == 0, "R10 reset again", align_strobe, 0);
    rst = 0; phase = "R10";
    seen = 0; tick(400);
    check(seen == 0, "R10 no strobe after reset", seen, 0);
    finish_run();
  end
endmodule